// File: doc/BRIEF.md
# Segmented Multi-Pattern Byte Matcher

This block searches a buffered byte stream for a fixed set of four strings: AB, ABG, BEDE and EF. Software or an upstream engine first writes the stream into an internal buffer through a byte write port, one byte per cycle. It then gives the valid length and pulses start. The buffer is cut into equal segments, one per lane. All lanes run at the same time, and each lane walks its own copy of one shared automaton. The automaton uses forward edges plus fallback edges, so the walk never rescans bytes it has already passed.

A string can begin near the end of one segment and finish inside the next. To catch it, each lane keeps reading past its own segment for up to three more bytes, which is the longest string minus one. A lane keeps only the hits that begin inside its own segment, so every hit is reported by exactly one lane. Hits leave the block on a valid/ready stream that carries a string code and the buffer index of the string's last byte. When every lane has finished and the last hit has been accepted, the block raises done.

Top module: `seg_ac_matcher`

## Requirements
- R1: The block reports each string with a code: AB = 0, ABG = 1, BEDE = 2, EF = 3. matchEnd is the buffer index of the string's last byte. When one string is a prefix of another (AB inside ABG), both are reported.
- R2: When the automaton has no forward edge for the current byte, it takes one fallback step and presents the same byte again. It repeats this until a forward edge is taken. The idle state simply consumes any byte it has no edge for. So in ABEDE, AB ends at index 1 and BEDE ends at index 4.
- R3: Every occurrence that lies wholly inside [0, streamLen) is reported exactly once. This holds for occurrences that cross a segment boundary and for occurrences that overlap each other.
- R4: A lane reads at most SEG_LEN + 3 bytes starting at its segment base, and never reads at or past streamLen. Bytes at or beyond streamLen never take part in a hit. A lane whose base is not below streamLen does no work. A streamLen larger than the buffer is treated as the full buffer.
- R5: Each forward step and each fallback step takes one cycle. On a stream with no hits, done goes high a number of clock edges after the start edge equal to the number of forward and fallback steps of the slowest lane, plus one. For streamLen = 0, that is one edge.
- R6: While matchValid is high and matchReady is low, matchValid stays high and matchId and matchEnd do not change.
- R7: When several lanes hold hits at once, they are granted round robin. The search starts at lane 0 after each start, and after each grant it moves to the lane after the one just granted.
- R8: busy is high from the edge after start until done. done rises only after every lane has finished and every hit has been accepted. It stays high with matchValid low until the next start. A start while busy is ignored.
- R9: After reset, matchValid, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one byte into the stream buffer |
| wrAddr | input | ADDR_W | Buffer index for the write |
| wrData | input | 8 | Byte to write |
| streamLen | input | LEN_W | Valid stream length, sampled at start |
| start | input | 1 | Launch a scan (ignored while busy) |
| matchReady | input | 1 | Consumer accepts the offered hit |
| matchValid | output | 1 | A hit is offered |
| matchId | output | 2 | String code of the hit |
| matchEnd | output | ADDR_W | Buffer index of the hit's last byte |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished and all hits drained |

## Verification
Two things can happen in the same cycle: several lanes can reach a hit at once, and the consumer can hold matchReady low at that moment. The bench provokes this by writing AB at the base of every segment. All four lanes then hit on the second step, while matchReady is held low for a dozen cycles. The bench judges the result in two ways. First, the offered hit (lane 0's) must stay frozen during the stall. Second, once matchReady rises, the hits must arrive in lane order 1, 9, 17, 25, and done must not rise until the last one has been taken.

// File: rtl/seg_ac_pkg.sv
package seg_ac_pkg;

  localparam int STATE_W = 4;
  localparam int ID_W    = 2;
  localparam int MAX_PAT = 4;

  localparam logic [7:0] CH_A = 8'h41;
  localparam logic [7:0] CH_B = 8'h42;
  localparam logic [7:0] CH_D = 8'h44;
  localparam logic [7:0] CH_E = 8'h45;
  localparam logic [7:0] CH_F = 8'h46;
  localparam logic [7:0] CH_G = 8'h47;

  typedef logic [STATE_W-1:0] acState_t;

  typedef struct packed {
    logic launch;
    logic run;
  } acStrobe_t;

  // forward edge lookup: {hit, nextState}
  function automatic logic [STATE_W:0] acGoto(input acState_t s, input logic [7:0] c);
    logic [STATE_W:0] r;
    r = '0;
    case (s)
      acState_t'(0): begin
        if (c == CH_A)      r = {1'b1, acState_t'(1)};
        else if (c == CH_B) r = {1'b1, acState_t'(4)};
        else if (c == CH_E) r = {1'b1, acState_t'(8)};
      end
      acState_t'(1): if (c == CH_B) r = {1'b1, acState_t'(2)};
      acState_t'(2): if (c == CH_G) r = {1'b1, acState_t'(3)};
      acState_t'(4): if (c == CH_E) r = {1'b1, acState_t'(5)};
      acState_t'(5): if (c == CH_D) r = {1'b1, acState_t'(6)};
      acState_t'(6): if (c == CH_E) r = {1'b1, acState_t'(7)};
      acState_t'(8): if (c == CH_F) r = {1'b1, acState_t'(9)};
      default: r = '0;
    endcase
    return r;
  endfunction

  // fallback edge: longest proper suffix that is also a prefix
  function automatic acState_t acFail(input acState_t s);
    case (s)
      acState_t'(2): return acState_t'(4);
      acState_t'(5): return acState_t'(8);
      acState_t'(7): return acState_t'(8);
      default:       return acState_t'(0);
    endcase
  endfunction

  // accepting states: {isFinal, stringCode}
  function automatic logic [ID_W:0] acFinal(input acState_t s);
    case (s)
      acState_t'(2): return {1'b1, 2'd0};
      acState_t'(3): return {1'b1, 2'd1};
      acState_t'(7): return {1'b1, 2'd2};
      acState_t'(9): return {1'b1, 2'd3};
      default:       return '0;
    endcase
  endfunction

  function automatic int patLen(input logic [ID_W-1:0] id);
    case (id)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/seg_ac_lane.sv
module seg_ac_lane
  import seg_ac_pkg::*;
#(
  parameter int BASE    = 0,
  parameter int SEG_LEN = 8,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acStrobe_t        strobe,
  input  logic [LEN_W-1:0] streamLen,
  input  logic [7:0]       curChar,
  input  logic             pendClr,
  output logic [LEN_W-1:0] rdPos,
  output logic             pendValid,
  output logic [ID_W-1:0]  pendId,
  output logic [LEN_W-1:0] pendEnd,
  output logic             laneBusy
);

  localparam int SEG_END  = BASE + SEG_LEN;
  localparam int SCAN_END = SEG_END + MAX_PAT - 1;

  acState_t         stateQ;
  logic [LEN_W-1:0] posQ, limitQ, pendEndQ;
  logic             armedQ, pendQ;
  logic [ID_W-1:0]  pendIdQ;

  logic [STATE_W:0] gotoRes;
  logic             gotoHit, hitFinal, inSegment, stepEn, scanLeft;
  acState_t         gotoNext;
  logic [ID_W:0]    finRes;

  always_comb begin
    gotoRes   = acGoto(stateQ, curChar);
    gotoHit   = gotoRes[STATE_W];
    gotoNext  = gotoRes[STATE_W-1:0];
    finRes    = acFinal(gotoNext);
    hitFinal  = gotoHit && finRes[ID_W];
    // hit start = posQ - len + 1 must lie before SEG_END
    inSegment = int'(posQ) < SEG_END + patLen(finRes[ID_W-1:0]) - 1;
    scanLeft  = armedQ && (posQ < limitQ);
    stepEn    = strobe.run && scanLeft && !pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ   <= '0;
      posQ     <= '0;
      limitQ   <= '0;
      armedQ   <= 1'b0;
      pendQ    <= 1'b0;
      pendIdQ  <= '0;
      pendEndQ <= '0;
    end else if (strobe.launch) begin
      stateQ <= '0;
      posQ   <= LEN_W'(BASE);
      pendQ  <= 1'b0;
      armedQ <= int'(streamLen) > BASE;
      limitQ <= (int'(streamLen) < SCAN_END) ? streamLen : LEN_W'(SCAN_END);
    end else begin
      if (pendClr) pendQ <= 1'b0;
      if (stepEn) begin
        if (gotoHit) begin
          stateQ <= gotoNext;
          posQ   <= posQ + 1'b1;
          if (hitFinal && inSegment) begin
            pendQ    <= 1'b1;
            pendIdQ  <= finRes[ID_W-1:0];
            pendEndQ <= posQ;
          end
        end else if (stateQ == '0) begin
          posQ <= posQ + 1'b1;
        end else begin
          stateQ <= acFail(stateQ);   // same byte presented again next cycle
        end
      end
    end
  end

  assign rdPos     = posQ;
  assign pendValid = pendQ;
  assign pendId    = pendIdQ;
  assign pendEnd   = pendEndQ;
  assign laneBusy  = scanLeft || pendQ;

  // R4: the read pointer never runs past the clipped scan limit
  a_r4_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armedQ |-> posQ <= limitQ)
    else $error("lane read pointer beyond limit");

  // R6: a held hit waits unchanged until the arbiter takes it
  a_r6_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ && !pendClr && !strobe.launch) |=> (pendQ && $stable(pendIdQ) && $stable(pendEndQ)))
    else $error("lane hit changed before grant");

endmodule

// File: rtl/seg_ac_datapath.sv
module seg_ac_datapath
  import seg_ac_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SEG_LEN   = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  acStrobe_t                              strobe,
  input  logic                                   wrEn,
  input  logic [$clog2(NUM_LANES*SEG_LEN)-1:0]   wrAddr,
  input  logic [7:0]                             wrData,
  input  logic [$clog2(NUM_LANES*SEG_LEN+1)-1:0] streamLen,
  input  logic                                   matchReady,
  output logic                                   matchValid,
  output logic [ID_W-1:0]                        matchId,
  output logic [$clog2(NUM_LANES*SEG_LEN)-1:0]   matchEnd,
  output logic                                   allIdle
);

  localparam int BUF_DEPTH = NUM_LANES * SEG_LEN;
  localparam int ADDR_W    = $clog2(BUF_DEPTH);
  localparam int LEN_W     = $clog2(BUF_DEPTH + 1);
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [7:0]       bufMem [BUF_DEPTH];
  logic [LEN_W-1:0] effLen;

  logic [LEN_W-1:0] rdPos   [NUM_LANES];
  logic [ID_W-1:0]  pendId  [NUM_LANES];
  logic [LEN_W-1:0] pendEnd [NUM_LANES];
  logic [NUM_LANES-1:0] pendV, laneBusy, pendClr;

  logic [LANE_W-1:0] rrPtr, gntIdx;
  logic              gntFound, loadOut;
  logic              outValid;
  logic [ID_W-1:0]   outId;
  logic [ADDR_W-1:0] outEnd;

  always_ff @(posedge clk) begin
    if (wrEn) bufMem[wrAddr] <= wrData;
  end

  assign effLen = (int'(streamLen) > BUF_DEPTH) ? LEN_W'(BUF_DEPTH) : streamLen;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    seg_ac_lane #(
      .BASE   (g * SEG_LEN),
      .SEG_LEN(SEG_LEN),
      .LEN_W  (LEN_W)
    ) uLane (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .streamLen(effLen),
      .curChar  (bufMem[rdPos[g][ADDR_W-1:0]]),
      .pendClr  (pendClr[g]),
      .rdPos    (rdPos[g]),
      .pendValid(pendV[g]),
      .pendId   (pendId[g]),
      .pendEnd  (pendEnd[g]),
      .laneBusy (laneBusy[g])
    );
  end

  // round robin: first holder at or after rrPtr
  always_comb begin
    gntFound = 1'b0;
    gntIdx   = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (!gntFound && pendV[(int'(rrPtr) + k) % NUM_LANES]) begin
        gntFound = 1'b1;
        gntIdx   = LANE_W'((int'(rrPtr) + k) % NUM_LANES);
      end
    end
    loadOut = gntFound && (!outValid || matchReady);
    pendClr = '0;
    if (loadOut) pendClr[gntIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr    <= '0;
      outValid <= 1'b0;
      outId    <= '0;
      outEnd   <= '0;
    end else if (strobe.launch) begin
      rrPtr    <= '0;
      outValid <= 1'b0;
    end else if (loadOut) begin
      outValid <= 1'b1;
      outId    <= pendId[gntIdx];
      outEnd   <= pendEnd[gntIdx][ADDR_W-1:0];
      rrPtr    <= LANE_W'((int'(gntIdx) + 1) % NUM_LANES);
    end else if (matchReady) begin
      outValid <= 1'b0;
    end
  end

  assign matchValid = outValid;
  assign matchId    = outId;
  assign matchEnd   = outEnd;
  assign allIdle    = (laneBusy == '0) && !outValid;

  // R6: offered hit is frozen while the consumer stalls
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !matchReady && !strobe.launch) |=> (outValid && $stable(outId) && $stable(outEnd)))
    else $error("output changed under backpressure");

  // R7: at most one lane is granted per cycle
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pendClr))
    else $error("more than one lane granted");

endmodule

// File: rtl/seg_ac_ctrl.sv
module seg_ac_ctrl
  import seg_ac_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      allIdle,
  output acStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} ctrlState_t;
  ctrlState_t stQ;

  always_comb begin
    strobe.launch = start && (stQ != S_RUN);
    strobe.run    = (stQ == S_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     stQ <= S_IDLE;
    else if (strobe.launch)         stQ <= S_RUN;
    else if (stQ == S_RUN && allIdle) stQ <= S_DONE;
  end

  assign busy = (stQ == S_RUN);
  assign done = (stQ == S_DONE);

  // R8: finished means every lane is quiet and the output is drained
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> allIdle)
    else $error("done while work remains");

endmodule

// File: rtl/seg_ac_matcher.sv
module seg_ac_matcher
  import seg_ac_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int SEG_LEN   = 8,
  localparam int BUF_DEPTH = NUM_LANES * SEG_LEN,
  localparam int ADDR_W    = $clog2(BUF_DEPTH),
  localparam int LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [LEN_W-1:0]  streamLen,
  input  logic              start,
  input  logic              matchReady,
  output logic              matchValid,
  output logic [1:0]        matchId,
  output logic [ADDR_W-1:0] matchEnd,
  output logic              busy,
  output logic              done
);

  acStrobe_t strobe;
  logic      allIdle;

  seg_ac_ctrl uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .allIdle(allIdle),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  seg_ac_datapath #(
    .NUM_LANES(NUM_LANES),
    .SEG_LEN  (SEG_LEN)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .streamLen (streamLen),
    .matchReady(matchReady),
    .matchValid(matchValid),
    .matchId   (matchId),
    .matchEnd  (matchEnd),
    .allIdle   (allIdle)
  );

endmodule

// File: tb/tb_seg_ac_matcher.sv
module tb_seg_ac_matcher;

  localparam int BD = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [5:0] streamLen = '0;
  logic       start = 1'b0;
  logic       matchReady = 1'b1;
  logic       matchValid, busy, done;
  logic [1:0] matchId;
  logic [4:0] matchEnd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] img [BD];
  int colN = 0;
  int colId [64];
  int colEnd [64];

  seg_ac_matcher dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .streamLen(streamLen), .start(start), .matchReady(matchReady),
    .matchValid(matchValid), .matchId(matchId), .matchEnd(matchEnd),
    .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (matchValid && matchReady && colN < 64) begin
      colId[colN]  = int'(matchId);
      colEnd[colN] = int'(matchEnd);
      colN++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string patStr(input int id);
    case (id)
      0: return "AB";
      1: return "ABG";
      2: return "BEDE";
      default: return "EF";
    endcase
  endfunction

  task automatic fillX();
    for (int i = 0; i < BD; i++) img[i] = 8'h58;
  endtask

  task automatic putStr(input int pos, input string s);
    for (int i = 0; i < s.len(); i++)
      if (pos + i < BD) img[pos + i] = s[i];
  endtask

  task automatic writeImg();
    for (int i = 0; i < BD; i++) begin
      wrEn = 1'b1; wrAddr = 5'(i); wrData = img[i];
      @(posedge clk); #1;
    end
    wrEn = 1'b0;
  endtask

  task automatic startRun(input int len);
    colN = 0;
    streamLen = 6'(len);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    while (!done && n < 3000) begin
      @(posedge clk); #1;
      n++;
    end
    chk(done == 1'b1, "R8 done reached", int'(done), 1);
  endtask

  task automatic checkModel(input int len, input string req);
    int expN = 0;
    int expId [64];
    int expEnd [64];
    for (int p = 0; p < len; p++) begin
      for (int id = 0; id < 4; id++) begin
        string s;
        bit hit;
        s = patStr(id);
        hit = (p + s.len() <= len);
        for (int i = 0; i < s.len(); i++)
          if (hit && img[p + i] != s[i]) hit = 1'b0;
        if (hit && expN < 64) begin
          expId[expN] = id; expEnd[expN] = p + s.len() - 1; expN++;
        end
      end
    end
    chk(colN == expN, {req, " hit count"}, colN, expN);
    for (int e = 0; e < expN; e++) begin
      int cnt = 0;
      for (int c = 0; c < colN; c++)
        if (colId[c] == expId[e] && colEnd[c] == expEnd[e]) cnt++;
      chk(cnt == 1, {req, " hit reported once"}, cnt, 1);
    end
  endtask

  task automatic checkAfterDone();
    int keep;
    keep = colN;
    repeat (4) @(posedge clk);
    #1;
    chk(done == 1'b1 && busy == 1'b0, "R8 done held", int'(done), 1);
    chk(matchValid == 1'b0 && colN == keep, "R8 no output after done", colN, keep);
  endtask

  task automatic tReset();
    chk(matchValid == 1'b0, "R9 matchValid low", int'(matchValid), 0);
    chk(busy == 1'b0, "R9 busy low", int'(busy), 0);
    chk(done == 1'b0, "R9 done low", int'(done), 0);
  endtask

  task automatic tFallbackWalk();
    int n;
    fillX(); putStr(0, "ABEDE"); writeImg();
    startRun(32);
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    waitDone(n);
    chk(colN == 2, "R2 two hits in ABEDE", colN, 2);
    chk(colId[0] == 0 && colEnd[0] == 1, "R1 AB ends at 1", colEnd[0], 1);
    chk(colId[1] == 2 && colEnd[1] == 4, "R2 BEDE after fallback ends at 4", colEnd[1], 4);
    checkModel(32, "R3 walk");
    checkAfterDone();
  endtask

  task automatic tBoundary();
    int n;
    int found = 0;
    fillX(); putStr(6, "BEDE"); putStr(15, "EF"); putStr(22, "ABG"); putStr(30, "AB");
    writeImg();
    startRun(32);
    waitDone(n);
    for (int c = 0; c < colN; c++) if (colId[c] == 2 && colEnd[c] == 9) found++;
    chk(found == 1, "R3 BEDE across boundary once", found, 1);
    checkModel(32, "R3 boundary");
  endtask

  task automatic tClip();
    int n;
    int late = 0;
    fillX(); putStr(19, "EF"); putStr(21, "EF"); putStr(17, "AB");
    writeImg();
    startRun(21);
    waitDone(n);
    for (int c = 0; c < colN; c++) if (colEnd[c] >= 21) late++;
    chk(late == 0, "R4 nothing past stream end", late, 0);
    checkModel(21, "R4 clipped");
  endtask

  task automatic tTiming();
    int n;
    fillX(); writeImg();
    startRun(8);
    waitDone(n);
    chk(n == 9, "R5 eight plain steps", n, 9);
    putStr(0, "A"); writeImg();
    startRun(8);
    waitDone(n);
    chk(n == 10, "R5 one fallback step", n, 10);
    startRun(0);
    waitDone(n);
    chk(n == 1 && colN == 0, "R5 empty stream", n, 1);
  endtask

  task automatic tArbStall();
    int n;
    logic [4:0] held;
    fillX();
    for (int l = 0; l < 4; l++) putStr(l * 8, "AB");
    writeImg();
    matchReady = 1'b0;
    startRun(32);
    repeat (12) @(posedge clk);
    #1;
    chk(matchValid == 1'b1 && matchEnd == 5'd1, "R7 lane 0 offered first", int'(matchEnd), 1);
    held = matchEnd;
    repeat (5) @(posedge clk);
    #1;
    chk(matchValid == 1'b1 && matchEnd == held, "R6 stable under stall", int'(matchEnd), int'(held));
    chk(done == 1'b0, "R8 not done with hits pending", int'(done), 0);
    matchReady = 1'b1;
    waitDone(n);
    chk(colN == 4, "R7 four hits", colN, 4);
    for (int k = 0; k < 4 && k < colN; k++)
      chk(colEnd[k] == 8 * k + 1, "R7 lane order", colEnd[k], 8 * k + 1);
    checkModel(32, "R3 arb");
  endtask

  task automatic tDense();
    int n;
    fillX();
    putStr(0, "ABGBEDEFABEFXBEDEDEABABGEFEFBEDE");
    writeImg();
    startRun(32);
    startRun(32); // R8: second start while busy is ignored
    waitDone(n);
    checkModel(32, "R3 dense");
    startRun(40); // R4: over-long length means full buffer
    waitDone(n);
    checkModel(32, "R4 length clamp");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    tFallbackWalk();
    tBoundary();
    tClip();
    tTiming();
    tArbStall();
    tDense();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule